// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block guards a processor against runaway software. A counter advances on the oscillator clock and, unless software restarts it in time, raises a one-cycle reset request. A three-bit rate code picks the period as a power of two of clock cycles, or switches the watchdog off. Software restarts the period by writing two key bytes to a service register: first `0x55`, then `0xAA`. Any other byte, or a misplaced key, counts as a fault and requests reset at once.

An optional window mode catches software that services too eagerly. With it enabled, the arming byte `0x55` is only welcome during roughly the last quarter of the period, and it is rejected again one prescaler step before expiry. A free-running prescaler sits in front of the period counter. As a result every time-out is late by up to one prescaler step and never early. A mode input separates normal operation from a special (test) mode. In normal mode the rate and window settings can be written once after reset, and the reset-suppress bit cannot be written at all. In special mode all of them can be written freely.

The register port is plain. A write strobe with a one-bit address selects either the control register or the service register. A combinational read returns the control register.

Top module: `windowed_watchdog`

## Requirements
- R1: After reset the control register reads `0x00` (watchdog off, window off, suppress off) and `rst_req` is low.
- R2: With rate code 0 no reset request is ever produced, and service writes of any value are ignored.
- R3: Rate codes 1..7 give a period of 2^(E-SCALE) cycles, with E = 13, 15, 17, 19, 21, 22, 23. The prescaler step G is 2^(11-SCALE) cycles for codes 1..3 and 2^(13-SCALE) cycles for codes 4..7. Counting clock edges from a restart, the time-out request appears after more than P and at most P+G edges.
- R4: A service write of `0x55` followed by a service write of `0xAA` restarts the period without a reset request. Repeating the pair more often than the period keeps `rst_req` low.
- R5: A service byte other than `0x55`/`0xAA`, or an `0xAA` not directly preceded by an accepted `0x55`, is a fault. A fault requests reset and restarts the period.
- R6: With window mode on, a `0x55` arriving while fewer than 3/4 of the period's prescaler steps have elapsed is a fault. One arriving after 13 of 16 steps (code 2) is accepted.
- R7: With window mode on, the window closes one step before the period ends. A `0x55` after N-1 of N steps is a fault.
- R8: At rate code 1 the window has zero width: with window mode on, every `0x55` is a fault.
- R9: In normal mode the first control write sets the rate and window bits and locks them. Later normal-mode writes leave them unchanged until reset.
- R10: The suppress bit changes only through special-mode writes. In special mode the rate, window and suppress bits are writable at any time. Control layout: bits [2:0] rate, bit 4 window enable, bit 5 reset suppress, other bits read 0.
- R11: While the suppress bit is set, neither a time-out nor a fault raises `rst_req`.
- R12: `rst_req` is high for exactly one cycle per request. An event in the cycle right after a request merges into it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = special mode (all control bits writable), 0 = normal mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = service register |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read select; 0 returns the control register, 1 returns zero |
| rd_data | output | 8 | Read data (combinational) |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest case is landing a `0x55` inside, or just outside, the window edge. The prescaler runs freely, so the phase of the first step after a restart is unknown from the ports. The bench starts each window case with a deliberate fault, which restarts the period at a known edge. It then places the key at an edge offset that is a whole multiple of the prescaler step. At such an offset the elapsed step count is the same whatever the prescaler phase, which makes the early, accepted and late outcomes deterministic. Time-out lengths are checked against a range one step wide for the same reason.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned RATE_W        = 3;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned FAST_GRAN_EXP = 11;
  localparam int unsigned SLOW_GRAN_EXP = 13;
  localparam int unsigned MAX_EXP       = 23;
  // step counter must hold the largest step count (2^(23-13)) itself
  localparam int unsigned CNT_W         = MAX_EXP - SLOW_GRAN_EXP + 1;

  localparam int unsigned CFG_RATE_LSB  = 0;
  localparam int unsigned CFG_WIN_BIT   = 4;
  localparam int unsigned CFG_DIS_BIT   = 5;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_SVC  = 1'b1;

  localparam logic [BYTE_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_FIRE = 8'hAA;

  typedef enum logic {SVC_IDLE, SVC_ARMED} svc_state_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              win_en;
    logic              rst_dis;
  } wdg_cfg_t;

  // codes 1..3 step on the fine prescaler tap
  function automatic logic rate_is_fast(input logic [RATE_W-1:0] code);
    return (code != '0) && (code <= 3'd3);
  endfunction

  // log2 of the number of prescaler steps in one period
  function automatic int unsigned steps_log2(input logic [RATE_W-1:0] code);
    case (code)
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 6;
      3'd5:    return 8;
      3'd6:    return 9;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs
  import wdg_pkg::*;
#(
  parameter logic [RATE_W-1:0] RST_RATE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              wr,
  input  logic [RATE_W-1:0] rate_in,
  input  logic              win_in,
  input  logic              dis_in,
  output wdg_cfg_t          cfg
);
  logic locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.rate    <= RST_RATE;
      cfg.win_en  <= 1'b0;
      cfg.rst_dis <= 1'b0;
      locked      <= 1'b0;
    end else if (wr) begin
      if (special_mode) begin
        cfg.rate    <= rate_in;
        cfg.win_en  <= win_in;
        cfg.rst_dis <= dis_in;
      end else if (!locked) begin
        cfg.rate   <= rate_in;
        cfg.win_en <= win_in;
        locked     <= 1'b1;
      end
    end
  end

  assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !special_mode) |=> $stable({cfg.rate, cfg.win_en}));

  assert_dis_special_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !special_mode |=> $stable(cfg.rst_dis));
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
  import wdg_pkg::*;
#(
  // divides every period by 2^SCALE; must stay at or below 10
  parameter int unsigned SCALE = 0
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_fast,
  output logic tick_slow
);
  localparam int unsigned FG = FAST_GRAN_EXP - SCALE;
  localparam int unsigned SG = SLOW_GRAN_EXP - SCALE;

  logic [SG-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;
  end

  assign tick_fast = &pre[FG-1:0];
  assign tick_slow = &pre;
endmodule

// File: rtl/wdg_period.sv
module wdg_period
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              tick_fast,
  input  logic              tick_slow,
  input  logic              restart,
  output logic              timeout,
  output logic              in_window
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] TWO = {{(CNT_W-2){1'b0}}, 2'b10};

  logic             rate_on;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] open_at;
  logic [CNT_W-1:0] close_at;

  assign rate_on  = (rate != '0);
  assign tick     = rate_is_fast(rate) ? tick_fast : tick_slow;
  assign limit    = rate_on ? (ONE << steps_log2(rate)) : '0;
  assign open_at  = limit - (limit >> 2);
  assign close_at = limit - TWO;

  assign timeout   = rate_on && tick && (cnt >= limit);
  assign in_window = rate_on && (cnt >= open_at) && (cnt <= close_at);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!rate_on || restart) cnt <= '0;
    else if (tick && !(&cnt))     cnt <= cnt + ONE;
  end

  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/wdg_service.sv
module wdg_service
  import wdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_wr,
  input  logic [BYTE_W-1:0] svc_data,
  input  logic              win_en,
  input  logic              in_window,
  input  logic              clear,
  output logic              restart_ok,
  output logic              fault
);
  svc_state_e state, state_nxt;

  always_comb begin
    state_nxt  = state;
    restart_ok = 1'b0;
    fault      = 1'b0;
    if (svc_wr) begin
      if (svc_data == KEY_ARM) begin
        if (win_en && !in_window) begin
          fault     = 1'b1;
          state_nxt = SVC_IDLE;
        end else begin
          state_nxt = SVC_ARMED;
        end
      end else if (svc_data == KEY_FIRE) begin
        if (state == SVC_ARMED) restart_ok = 1'b1;
        else                    fault      = 1'b1;
        state_nxt = SVC_IDLE;
      end else begin
        fault     = 1'b1;
        state_nxt = SVC_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state <= SVC_IDLE;
    else if (clear) state <= SVC_IDLE;
    else            state <= state_nxt;
  end
endmodule

// File: rtl/windowed_watchdog.sv
module windowed_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned       SCALE    = 0,
  parameter logic [RATE_W-1:0] RST_RATE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rst_req
);
  wdg_cfg_t cfg;
  logic     tick_fast, tick_slow;
  logic     timeout, in_window;
  logic     restart_ok, fault;
  logic     rate_on;
  logic     ctrl_wr, svc_wr;

  assign rate_on = (cfg.rate != '0);
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign svc_wr  = wr_en && (wr_addr == ADDR_SVC) && rate_on;

  wdg_cfg_regs #(.RST_RATE(RST_RATE)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .wr           (ctrl_wr),
    .rate_in      (wr_data[CFG_RATE_LSB +: RATE_W]),
    .win_in       (wr_data[CFG_WIN_BIT]),
    .dis_in       (wr_data[CFG_DIS_BIT]),
    .cfg          (cfg)
  );

  wdg_prescaler #(.SCALE(SCALE)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow)
  );

  wdg_period u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate      (cfg.rate),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .restart   (restart_ok | timeout | fault),
    .timeout   (timeout),
    .in_window (in_window)
  );

  wdg_service u_svc (
    .clk        (clk),
    .rst_n      (rst_n),
    .svc_wr     (svc_wr),
    .svc_data   (wr_data),
    .win_en     (cfg.win_en),
    .in_window  (in_window),
    .clear      (timeout | ~rate_on),
    .restart_ok (restart_ok),
    .fault      (fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= (timeout | fault) & ~cfg.rst_dis & ~rst_req;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_CTRL) begin
      rd_data[CFG_RATE_LSB +: RATE_W] = cfg.rate;
      rd_data[CFG_WIN_BIT]            = cfg.win_en;
      rd_data[CFG_DIS_BIT]            = cfg.rst_dis;
    end
  end

  assert_off_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.rate == '0) |=> !rst_req);

  assert_bad_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_SVC && wr_data != KEY_ARM && wr_data != KEY_FIRE
     && cfg.rate != '0 && !cfg.rst_dis && !rst_req) |=> rst_req);

  assert_suppress_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.rst_dis |=> !rst_req);

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
endmodule

// File: tb/windowed_watchdog_test.sv
module windowed_watchdog_test;
  localparam int unsigned SCALE = 8;
  localparam int GF = 1 << (11 - SCALE);
  localparam int GS = 1 << (13 - SCALE);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       rst_req;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  windowed_watchdog #(.SCALE(SCALE)) uut (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req)
  );

  // {service byte, expected pulse}, rate code 7, window off
  localparam logic [8:0] VEC [13] = '{
    {8'hAA, 1'b1}, {8'h55, 1'b0}, {8'hAA, 1'b0}, {8'hAA, 1'b1},
    {8'h55, 1'b0}, {8'h55, 1'b0}, {8'hAA, 1'b0}, {8'h3C, 1'b1},
    {8'h55, 1'b0}, {8'h00, 1'b1}, {8'hAA, 1'b1}, {8'h55, 1'b0},
    {8'hAA, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; sampled at the next posedge; returns at the following negedge
  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // write sampled e edges after the edge of the last write
  task automatic wr_at(input int e, input logic a, input logic [7:0] d);
    repeat (e - 1) @(negedge clk);
    wr(a, d);
  endtask

  task automatic measure(input logic [2:0] code, input int p, input int g, input string req);
    int k;
    special_mode = 1'b1;
    wr(1'b0, {5'b0, code});
    wr(1'b1, 8'h00);           // fault restarts the period
    k = 0;
    while (k < p + g + 10) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (rst_req) break;
    end
    chk(k > p && k <= p + g, req, k, p + g);
    @(negedge clk);
    chk(rst_req == 1'b0, "R12", int'(rst_req), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rst_req == 1'b0, "R1", int'(rst_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 8'h00 && rst_req == 1'b0, "R1", int'(rd_data), 0);

    // write-once and suppress-bit protection in normal mode
    wr(1'b0, 8'h32);
    chk(rd_data == 8'h12, "R10", int'(rd_data), 8'h12);
    wr(1'b0, 8'h07);
    chk(rd_data == 8'h12, "R9", int'(rd_data), 8'h12);
    special_mode = 1'b1;
    wr(1'b0, 8'h25);
    chk(rd_data == 8'h25, "R10", int'(rd_data), 8'h25);
    wr(1'b0, 8'h00);
    special_mode = 1'b0;
    wr(1'b0, 8'h03);
    chk(rd_data == 8'h00, "R9", int'(rd_data), 0);
    rd_addr = 1'b1;
    #0 chk(rd_data == 8'h00, "R10", int'(rd_data), 0);
    rd_addr = 1'b0;

    // watchdog off: nothing happens
    special_mode = 1'b1;
    begin
      int seen = 0;
      repeat (300) begin @(negedge clk); if (rst_req) seen++; end
      wr(1'b1, 8'h13); if (rst_req) seen++;
      @(negedge clk);
      wr(1'b1, 8'hAA); if (rst_req) seen++;
      chk(seen == 0, "R2", seen, 0);
    end

    // service byte table at rate 7
    wr(1'b0, 8'h07);
    @(negedge clk);
    for (int i = 0; i < 13; i++) begin
      wr(1'b1, VEC[i][8:1]);
      chk(rst_req == VEC[i][0], (VEC[i][0] ? "R5" : "R4"), int'(rst_req), int'(VEC[i][0]));
      @(negedge clk);
    end

    // time-out lengths
    measure(3'd1, 4 * 4 * GF / 4 * 1, GF, "R3");
    measure(3'd4, 64 * GS, GS, "R3");
    measure(3'd7, 1024 * GS, GS, "R3");

    // restarting in time keeps reset away
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h00);
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      int seen = 0;
      repeat (14) begin @(negedge clk); if (rst_req) seen++; end
      wr(1'b1, 8'h55); if (rst_req) seen++;
      wr(1'b1, 8'hAA); if (rst_req) seen++;
      chk(seen == 0, "R4", seen, 0);
    end

    // window mode at code 2: 16 steps of GF cycles
    wr(1'b0, 8'h12);
    wr(1'b1, 8'hAA);                   // fault, restart
    wr_at(8 * GF, 1'b1, 8'h55);        // 8 steps: too early
    chk(rst_req == 1'b1, "R6", int'(rst_req), 1);
    wr_at(13 * GF, 1'b1, 8'h55);       // 13 steps: inside window
    chk(rst_req == 1'b0, "R6", int'(rst_req), 0);
    wr(1'b1, 8'hAA);
    chk(rst_req == 1'b0, "R6", int'(rst_req), 0);
    wr_at(15 * GF, 1'b1, 8'h55);       // 15 of 16 steps: window closed
    chk(rst_req == 1'b1, "R7", int'(rst_req), 1);

    // zero-width window at the fastest rate
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h00);
    wr_at(3 * GF, 1'b1, 8'h55);
    chk(rst_req == 1'b1, "R8", int'(rst_req), 1);

    // suppress bit
    wr(1'b0, 8'h21);
    @(negedge clk);
    begin
      int seen = 0;
      repeat (100) begin @(negedge clk); if (rst_req) seen++; end
      wr(1'b1, 8'h13); if (rst_req) seen++;
      chk(seen == 0, "R11", seen, 0);
      wr(1'b0, 8'h01);
      seen = 0;
      repeat (60) begin @(negedge clk); if (rst_req) seen++; end
      chk(seen >= 1, "R11", seen, 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule